// File: doc/BRIEF.md
# Flash In-System Programming Controller

This block sits between a processor's byte-wide register bus and an on-chip flash array and carries out reads, byte programs, page erases and whole-array erases for the processor. Software loads a 16-bit target address into two byte registers, loads a data byte when it programs, and starts an operation on a separate command port. The command port stands in for a control register that software cannot reach over the register bus. Program and erase pulses scale with a timing byte that software sets to match the clock frequency. The controller raises a busy flag for each pulse and gives a one-cycle done strobe when the operation finishes. A sticky error flag records every refused or colliding command.

The flash array is a behavioural model driven by program and erase pulses. A change takes effect when its pulse falls. The top byte of the array is an option byte. Its bit 0 is the flash-execute flag, and its bit 1 is a security bit that is active low, so the array is secured when the bit reads 0. When reset ends, the controller samples the flash-execute flag once and chooses the boot vector from it.

Top module: `flash_isp_ctrl`

## Requirements
- R1: After reset both address bytes read 0x00, the timing register reads TIM_RST, and busy_o, done_o and err_o are 0.
- R2: Register select codes are 0 = address low, 1 = address high, 2 = write data, 3 = read data, 4 = timing. Codes 0, 1, 2 and 4 can be written and read back. A write with code 3 has no effect on the read-data register. Codes 5 to 7 read as 0x00.
- R3: Command codes are 0 = read, 1 = program, 2 = page erase, 3 = mass erase. A read is accepted when the controller is not busy. It loads the read-data register one cycle after the command, from the array byte at the address taken modulo the array size.
- R4: A byte program can only clear bits: the stored byte becomes the old byte AND the write-data byte.
- R5: A program pulse lasts timing × WR_SCALE cycles and an erase pulse lasts timing × ER_SCALE cycles. busy_o stays high for the pulse plus one recovery cycle. done_o is high for exactly one cycle, the first cycle after busy_o falls.
- R6: A page erase sets every byte of the aligned 2^PAGE_W-byte page that holds the address to 0xFF and leaves every other byte unchanged.
- R7: A mass erase sets the whole array to 0xFF, but only when both address bytes are 0x00. With any other address the mass erase is refused: no pulse, no change to the array, and err_o set.
- R8: When the timing register holds 0, program and erase commands are refused: busy_o stays low, the array is unchanged, and err_o is set. Reads still work.
- R9: A command that arrives while busy_o is high is ignored and sets err_o. err_o stays set until reset.
- R10: The option byte sits at the top array address, and address 0xFFFF always reads it. When the array is secured (option bit 1 = 0), every read at any other address returns 0xFF.
- R11: In the first cycle after reset, boot_flash_o takes option bit 0. boot_vec_o is 0x0000 when boot_flash_o is 1 and BOOT_VEC otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register select |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Selected register contents |
| cmd_valid_i | input | 1 | Command strobe, one cycle |
| cmd_op_i | input | 2 | Command code |
| busy_o | output | 1 | Pulse or recovery in progress |
| done_o | output | 1 | One-cycle completion strobe |
| err_o | output | 1 | Sticky refused/collision flag |
| prog_pulse_o | output | 1 | Program pulse to array |
| erase_pulse_o | output | 1 | Erase pulse to array |
| boot_flash_o | output | 1 | Boot from flash selected |
| boot_vec_o | output | 16 | Selected boot vector |

## Verification
The bench programs the whole small array with a computed pattern, programs part of it a second time, and reads every byte back. A controller that overwrote bytes instead of ANDing them, or that truncated the address wrongly, fails many of these compares. The bench counts pulse and busy cycles under two timing values, so a missing or extra cycle in the counter or in recovery shows up. It erases a page from an unaligned address and checks the bytes just outside both page boundaries. It sends a program command in the middle of an erase, a mass erase with a nonzero address, and a program with timing 0; a design that acted on any of these would alter bytes the bench reads back. It also clears the flash-execute flag and sets security, then checks that the boot vector changes after reset, that ordinary reads are masked while the 0xFFFF alias still works, and that a mass erase removes security.

// File: rtl/flash_isp_pkg.sv
package flash_isp_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    OP_READ        = 2'd0,
    OP_WRITE       = 2'd1,
    OP_PAGE_ERASE  = 2'd2,
    OP_MASS_ERASE  = 2'd3
  } isp_op_e;

  localparam logic [2:0] SEL_ADR_LO = 3'd0;
  localparam logic [2:0] SEL_ADR_HI = 3'd1;
  localparam logic [2:0] SEL_WDATA  = 3'd2;
  localparam logic [2:0] SEL_RDATA  = 3'd3;
  localparam logic [2:0] SEL_TIMING = 3'd4;
endpackage

// File: rtl/isp_regs.sv
module isp_regs
  import flash_isp_pkg::*;
#(
  parameter logic [BYTE_W-1:0] TIM_RST = 8'd20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        sel_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              rd_load_i,
  input  logic [BYTE_W-1:0] rd_value_i,
  output logic [15:0]       adr_o,
  output logic [BYTE_W-1:0] wdat_o,
  output logic [BYTE_W-1:0] tim_o,
  output logic [BYTE_W-1:0] rdat_o,
  output logic [BYTE_W-1:0] bus_rdata_o
);
  logic [BYTE_W-1:0] adr_lo_q, adr_hi_q, tim_q, wdat_q, rdat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adr_lo_q <= '0;
      adr_hi_q <= '0;
      tim_q    <= TIM_RST;
    end else if (we_i) begin
      case (sel_i)
        SEL_ADR_LO: adr_lo_q <= wdata_i;
        SEL_ADR_HI: adr_hi_q <= wdata_i;
        SEL_TIMING: tim_q    <= wdata_i;
        default: ;
      endcase
    end
  end

  // data registers carry no reset value
  always_ff @(posedge clk_i) begin
    if (we_i && sel_i == SEL_WDATA) wdat_q <= wdata_i;
    if (rd_load_i) rdat_q <= rd_value_i;
  end

  always_comb begin
    case (sel_i)
      SEL_ADR_LO: bus_rdata_o = adr_lo_q;
      SEL_ADR_HI: bus_rdata_o = adr_hi_q;
      SEL_WDATA:  bus_rdata_o = wdat_q;
      SEL_RDATA:  bus_rdata_o = rdat_q;
      SEL_TIMING: bus_rdata_o = tim_q;
      default:    bus_rdata_o = '0;
    endcase
  end

  assign adr_o  = {adr_hi_q, adr_lo_q};
  assign wdat_o = wdat_q;
  assign tim_o  = tim_q;
  assign rdat_o = rdat_q;

  assert_rdata_ro_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_RDATA && !rd_load_i) |=> $stable(rdat_q));
endmodule

// File: rtl/isp_seq.sv
module isp_seq
  import flash_isp_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int PAGE_W   = 6,
  parameter int WR_SCALE = 16,
  parameter int ER_SCALE = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [15:0]       adr_i,
  input  logic [BYTE_W-1:0] wdat_i,
  input  logic [BYTE_W-1:0] tim_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              prog_o,
  output logic              erase_o,
  output logic              mass_o,
  output logic [ADDR_W-1:0] tgt_adr_o,
  output logic [BYTE_W-1:0] tgt_dat_o,
  output logic              rd_load_o,
  output logic [15:0]       rd_adr_o
);
  localparam int MAX_SCALE = (ER_SCALE > WR_SCALE) ? ER_SCALE : WR_SCALE;
  localparam int CNT_W     = BYTE_W + $clog2(MAX_SCALE) + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_PULSE, ST_RECOV} st_e;

  st_e               st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              prog_q, erase_q, mass_q, done_q, err_q, rd_load_q;
  logic [ADDR_W-1:0] tgt_q;
  logic [BYTE_W-1:0] dat_q;
  logic [15:0]       rd_adr_q;

  isp_op_e           op;
  logic              busy, tim_ok, adr_zero;
  logic [CNT_W-1:0]  wr_len, er_len;
  logic [ADDR_W-1:0] page_base;

  assign op        = isp_op_e'(cmd_op_i);
  assign busy      = (st_q != ST_IDLE);
  assign tim_ok    = (tim_i != '0);
  assign adr_zero  = (adr_i == 16'h0000);
  assign wr_len    = CNT_W'(tim_i) * CNT_W'(WR_SCALE);
  assign er_len    = CNT_W'(tim_i) * CNT_W'(ER_SCALE);
  assign page_base = {adr_i[ADDR_W-1:PAGE_W], {PAGE_W{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; cnt_q <= '0;
      prog_q <= 1'b0; erase_q <= 1'b0; mass_q <= 1'b0;
      done_q <= 1'b0; err_q <= 1'b0; rd_load_q <= 1'b0;
      tgt_q <= '0; dat_q <= '0; rd_adr_q <= '0;
    end else begin
      done_q    <= 1'b0;
      rd_load_q <= 1'b0;
      if (cmd_valid_i && busy) err_q <= 1'b1;
      case (st_q)
        ST_IDLE: if (cmd_valid_i) begin
          case (op)
            OP_READ: begin
              rd_load_q <= 1'b1;
              rd_adr_q  <= adr_i;
            end
            OP_WRITE: if (!tim_ok) err_q <= 1'b1;
            else begin
              st_q <= ST_PULSE; prog_q <= 1'b1; cnt_q <= wr_len;
              tgt_q <= adr_i[ADDR_W-1:0]; dat_q <= wdat_i;
            end
            OP_PAGE_ERASE: if (!tim_ok) err_q <= 1'b1;
            else begin
              st_q <= ST_PULSE; erase_q <= 1'b1; mass_q <= 1'b0;
              cnt_q <= er_len; tgt_q <= page_base;
            end
            default: if (!tim_ok || !adr_zero) err_q <= 1'b1;
            else begin
              st_q <= ST_PULSE; erase_q <= 1'b1; mass_q <= 1'b1;
              cnt_q <= er_len; tgt_q <= '0;
            end
          endcase
        end
        ST_PULSE: if (cnt_q == CNT_W'(1)) begin
          prog_q <= 1'b0; erase_q <= 1'b0; st_q <= ST_RECOV;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        ST_RECOV: begin
          st_q <= ST_IDLE; done_q <= 1'b1; mass_q <= 1'b0;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = busy;
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign prog_o    = prog_q;
  assign erase_o   = erase_q;
  assign mass_o    = mass_q;
  assign tgt_adr_o = tgt_q;
  assign tgt_dat_o = dat_q;
  assign rd_load_o = rd_load_q;
  assign rd_adr_o  = rd_adr_q;

  assert_collide_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cmd_valid_i) |=> err_o);
  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  assert_zero_tim_refused_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cmd_valid_i && cmd_op_i != 2'd0 && tim_i == '0) |=> !busy_o);
  assert_mass_nonzero_refused_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cmd_valid_i && cmd_op_i == 2'd3 && adr_i != 16'h0000) |=> (!busy_o && err_o));
  assert_done_follows_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  assert_pulse_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_o, erase_o}));
  assert_pulse_end_recov_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(prog_o) || $fell(erase_o)) |=> $fell(busy_o));
endmodule

// File: rtl/flash_array_model.sv
module flash_array_model
  import flash_isp_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_i,
  input  logic              erase_i,
  input  logic              mass_i,
  input  logic [ADDR_W-1:0] adr_i,
  input  logic [BYTE_W-1:0] dat_i,
  input  logic [ADDR_W-1:0] rd_adr_i,
  output logic [BYTE_W-1:0] rd_dat_o,
  output logic [BYTE_W-1:0] opt_o
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int PAGE_SZ = 1 << PAGE_W;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic prog_d, erase_d, commit_prog, commit_erase;

  // nonvolatile contents: erased at power-up, untouched by reset
  initial for (int i = 0; i < DEPTH; i++) mem[i] = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_d  <= 1'b0;
      erase_d <= 1'b0;
    end else begin
      prog_d  <= prog_i;
      erase_d <= erase_i;
    end
  end

  assign commit_prog  = prog_d & ~prog_i;
  assign commit_erase = erase_d & ~erase_i;

  always_ff @(posedge clk_i) begin
    if (commit_prog) mem[adr_i] <= mem[adr_i] & dat_i;
    if (commit_erase) begin
      if (mass_i) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else begin
        for (int i = 0; i < PAGE_SZ; i++)
          mem[{adr_i[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= '1;
      end
    end
  end

  assign rd_dat_o = mem[rd_adr_i];
  assign opt_o    = mem[DEPTH-1];

  assert_prog_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_i && prog_d) |-> ($stable(adr_i) && $stable(dat_i)));
  assert_erase_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_i && erase_d) |-> ($stable(adr_i) && $stable(mass_i)));
endmodule

// File: rtl/flash_isp_ctrl.sv
module flash_isp_ctrl
  import flash_isp_pkg::*;
#(
  parameter int          ADDR_W   = 11,
  parameter int          PAGE_W   = 6,
  parameter int          WR_SCALE = 16,
  parameter int          ER_SCALE = 128,
  parameter logic [7:0]  TIM_RST  = 8'd20,
  parameter logic [15:0] BOOT_VEC = 16'h8000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_sel_i,
  input  logic [7:0]  reg_wdata_i,
  output logic [7:0]  reg_rdata_o,
  input  logic        cmd_valid_i,
  input  logic [1:0]  cmd_op_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o,
  output logic        prog_pulse_o,
  output logic        erase_pulse_o,
  output logic        boot_flash_o,
  output logic [15:0] boot_vec_o
);
  localparam logic [15:0] OPT_ALIAS = 16'hFFFF;

  logic [15:0]       adr, rd_adr;
  logic [BYTE_W-1:0] wdat, tim, rdat, rd_value, arr_dat, opt;
  logic              rd_load, prog, erase, mass, secured, alias_hit;
  logic [ADDR_W-1:0] tgt_adr;
  logic [BYTE_W-1:0] tgt_dat;
  logic              boot_done_q, boot_flash_q;

  isp_regs #(.TIM_RST(TIM_RST)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i),
    .rd_load_i(rd_load), .rd_value_i(rd_value),
    .adr_o(adr), .wdat_o(wdat), .tim_o(tim), .rdat_o(rdat),
    .bus_rdata_o(reg_rdata_o)
  );

  isp_seq #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_SCALE(WR_SCALE), .ER_SCALE(ER_SCALE)) u_seq (
    .clk_i, .rst_ni,
    .cmd_valid_i, .cmd_op_i, .adr_i(adr), .wdat_i(wdat), .tim_i(tim),
    .busy_o, .done_o, .err_o, .prog_o(prog), .erase_o(erase), .mass_o(mass),
    .tgt_adr_o(tgt_adr), .tgt_dat_o(tgt_dat), .rd_load_o(rd_load), .rd_adr_o(rd_adr)
  );

  flash_array_model #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
    .clk_i, .rst_ni,
    .prog_i(prog), .erase_i(erase), .mass_i(mass),
    .adr_i(tgt_adr), .dat_i(tgt_dat),
    .rd_adr_i(rd_adr[ADDR_W-1:0]), .rd_dat_o(arr_dat), .opt_o(opt)
  );

  // option bit 1 low means secured
  assign secured   = ~opt[1];
  assign alias_hit = (rd_adr == OPT_ALIAS);
  assign rd_value  = alias_hit ? opt : (secured ? '1 : arr_dat);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_done_q  <= 1'b0;
      boot_flash_q <= 1'b0;
    end else if (!boot_done_q) begin
      boot_done_q  <= 1'b1;
      boot_flash_q <= opt[0];
    end
  end

  assign boot_flash_o  = boot_flash_q;
  assign boot_vec_o    = boot_flash_q ? 16'h0000 : BOOT_VEC;
  assign prog_pulse_o  = prog;
  assign erase_pulse_o = erase;

  assert_secure_mask_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_load && secured && !alias_hit) |=> (rdat == 8'hFF));
  assert_alias_opt_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_load && alias_hit && !prog && !erase) |=> (rdat == $past(opt)));
  assert_boot_stable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_done_q |=> $stable(boot_flash_o));
endmodule

// File: tb/tb_flash_isp_ctrl.sv
module tb_flash_isp_ctrl;
  import flash_isp_pkg::*;

  localparam int          ADDR_W = 8;
  localparam int          PAGE_W = 4;
  localparam int          WRS    = 2;
  localparam int          ERS    = 4;
  localparam logic [7:0]  TRST   = 8'd3;
  localparam logic [15:0] BVEC   = 16'hC000;
  localparam int          DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, cmd_valid = 1'b0;
  logic [2:0] sel = '0;
  logic [7:0] wdata = '0, rdata;
  logic [1:0] cmd_op = '0;
  logic busy, done, err, prog_p, erase_p, boot_flash;
  logic [15:0] boot_vec;

  int n_chk = 0, n_fail = 0;
  logic [7:0] ref_mem [DEPTH];

  always #10 clk = ~clk;

  flash_isp_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_SCALE(WRS), .ER_SCALE(ERS),
                   .TIM_RST(TRST), .BOOT_VEC(BVEC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .busy_o(busy), .done_o(done), .err_o(err), .prog_pulse_o(prog_p),
    .erase_pulse_o(erase_p), .boot_flash_o(boot_flash), .boot_vec_o(boot_vec)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic reg_wr(logic [2:0] s, logic [7:0] v);
    we = 1'b1; sel = s; wdata = v;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic reg_rd(logic [2:0] s, output logic [7:0] v);
    sel = s; #1; v = rdata;
  endtask

  task automatic set_adr(logic [15:0] a);
    reg_wr(SEL_ADR_LO, a[7:0]);
    reg_wr(SEL_ADR_HI, a[15:8]);
  endtask

  task automatic issue(isp_op_e op);
    cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle(output int bc, output int pc, output logic d);
    bc = 0; pc = 0;
    while (busy && bc < 10000) begin
      bc++;
      if (prog_p || erase_p) pc++;
      @(negedge clk);
    end
    d = done;
  endtask

  task automatic do_write(logic [15:0] a, logic [7:0] d);
    int bc, pc; logic dn;
    set_adr(a);
    reg_wr(SEL_WDATA, d);
    issue(OP_WRITE);
    wait_idle(bc, pc, dn);
    ref_mem[a[ADDR_W-1:0]] &= d;
  endtask

  task automatic do_read(logic [15:0] a, output logic [7:0] v);
    set_adr(a);
    issue(OP_READ);
    @(negedge clk);
    reg_rd(SEL_RDATA, v);
  endtask

  task automatic sweep(string tag);
    logic [7:0] v;
    for (int a = 0; a < DEPTH; a++) begin
      do_read(16'(a), v);
      chk(tag, v, ref_mem[a]);
    end
  endtask

  initial begin
    logic [7:0] v, v0;
    int bc, pc;
    logic dn;
    for (int a = 0; a < DEPTH; a++) ref_mem[a] = 8'hFF;

    do_reset();
    // R1 reset state
    reg_rd(SEL_ADR_LO, v); chk("R1 adr_lo", v, 8'h00);
    reg_rd(SEL_ADR_HI, v); chk("R1 adr_hi", v, 8'h00);
    reg_rd(SEL_TIMING, v); chk("R1 timing", v, TRST);
    chk("R1 busy/done/err", {busy, done, err}, 3'b000);
    // R11 erased option byte -> boot from flash
    chk("R11 boot_flash", boot_flash, 1'b1);
    chk("R11 boot_vec", boot_vec, 16'h0000);

    // R2 register map
    set_adr(16'h015A);
    reg_rd(SEL_ADR_LO, v); chk("R2 adr_lo rb", v, 8'h5A);
    reg_rd(SEL_ADR_HI, v); chk("R2 adr_hi rb", v, 8'h01);
    reg_wr(SEL_WDATA, 8'h3C);
    reg_rd(SEL_WDATA, v); chk("R2 wdata rb", v, 8'h3C);
    reg_rd(SEL_RDATA, v0);
    reg_wr(SEL_RDATA, 8'h77);
    reg_rd(SEL_RDATA, v); chk("R2 rdata read-only", v, v0);
    for (int s = 5; s < 8; s++) begin
      reg_rd(3'(s), v); chk("R2 unmapped", v, 8'h00);
    end

    // R7/R5 mass erase at address 0
    set_adr(16'h0000);
    issue(OP_MASS_ERASE);
    wait_idle(bc, pc, dn);
    chk("R5 erase busy cycles", bc, 32'(TRST) * ERS + 1);
    chk("R5 erase pulse cycles", pc, 32'(TRST) * ERS);
    chk("R5 done strobe", dn, 1'b1);
    @(negedge clk);
    chk("R5 done one cycle", done, 1'b0);

    // R4 program whole array (except option byte), then AND a second pass
    for (int a = 0; a < DEPTH - 1; a++) do_write(16'(a), 8'((a * 37 + 11) & 8'hFF));
    for (int a = 0; a < 16; a++) do_write(16'(a), 8'((a * 13) ^ 8'hF0));
    sweep("R3/R4 readback");
    // R3 address taken modulo array size
    do_read(16'h0A05, v); chk("R3 addr wrap", v, ref_mem[5]);

    // R5 single program timing
    set_adr(16'h0030);
    reg_wr(SEL_WDATA, 8'h00);
    issue(OP_WRITE);
    wait_idle(bc, pc, dn);
    ref_mem[8'h30] = 8'h00;
    chk("R5 prog busy cycles", bc, 32'(TRST) * WRS + 1);
    chk("R5 prog pulse cycles", pc, 32'(TRST) * WRS);

    // R6 page erase from unaligned address
    set_adr(16'h0023);
    issue(OP_PAGE_ERASE);
    wait_idle(bc, pc, dn);
    for (int a = 16'h20; a < 16'h30; a++) ref_mem[a] = 8'hFF;
    sweep("R6 page erase");

    // R5 different timing value
    reg_wr(SEL_TIMING, 8'd5);
    reg_rd(SEL_TIMING, v); chk("R2 timing rb", v, 8'd5);
    set_adr(16'h0040);
    reg_wr(SEL_WDATA, 8'h0F);
    issue(OP_WRITE);
    wait_idle(bc, pc, dn);
    ref_mem[8'h40] &= 8'h0F;
    chk("R5 prog busy tim5", bc, 32'd5 * WRS + 1);
    chk("R5 prog pulse tim5", pc, 32'd5 * WRS);

    // R8 zero timing refuses program
    reg_wr(SEL_TIMING, 8'd0);
    set_adr(16'h0041);
    reg_wr(SEL_WDATA, 8'h00);
    issue(OP_WRITE);
    chk("R8 no busy", busy, 1'b0);
    chk("R8 err set", err, 1'b1);
    do_read(16'h0041, v); chk("R8 array unchanged", v, ref_mem[8'h41]);

    do_reset();
    chk("R1 err cleared", err, 1'b0);
    reg_rd(SEL_TIMING, v); chk("R1 timing restored", v, TRST);

    // R9 collision: program while page erase runs
    reg_wr(SEL_WDATA, 8'h00);
    set_adr(16'h0050);
    issue(OP_PAGE_ERASE);
    chk("R9 busy during erase", busy, 1'b1);
    issue(OP_WRITE);
    wait_idle(bc, pc, dn);
    for (int a = 16'h50; a < 16'h60; a++) ref_mem[a] = 8'hFF;
    chk("R9 err sticky", err, 1'b1);
    do_read(16'h0050, v); chk("R9 write ignored", v, 8'hFF);
    repeat (3) @(negedge clk);
    chk("R9 err holds", err, 1'b1);

    do_reset();
    // R7 mass erase with nonzero address refused
    set_adr(16'h0001);
    issue(OP_MASS_ERASE);
    chk("R7 no busy", busy, 1'b0);
    chk("R7 err set", err, 1'b1);
    do_read(16'h0000, v); chk("R7 array intact", v, ref_mem[0]);

    do_reset();
    // R11 clear flash-execute flag
    do_write(16'h00FF, 8'hFE);
    do_reset();
    chk("R11 boot rom", boot_flash, 1'b0);
    chk("R11 boot_vec rom", boot_vec, BVEC);
    // R10 option byte at top address and alias
    do_read(16'hFFFF, v); chk("R10 alias", v, 8'hFE);
    do_read(16'h00FF, v); chk("R10 top addr", v, 8'hFE);

    // R10 secure: clear bit 1
    do_write(16'h00FF, 8'hFD);
    do_read(16'h0010, v); chk("R10 secured mask", v, 8'hFF);
    do_read(16'h00FF, v); chk("R10 secured top", v, 8'hFF);
    do_read(16'hFFFF, v); chk("R10 secured alias", v, 8'hFC);

    // R7 mass erase clears security
    set_adr(16'h0000);
    issue(OP_MASS_ERASE);
    wait_idle(bc, pc, dn);
    for (int a = 0; a < DEPTH; a++) ref_mem[a] = 8'hFF;
    do_reset();
    chk("R11 boot flash again", boot_flash, 1'b1);
    do_read(16'hFFFF, v); chk("R7 option erased", v, 8'hFF);
    sweep("R7 mass erase");

    summary();
    $finish;
  end
endmodule